// File: doc/BRIEF.md
# Circular Queue Pointer Register Unit

This unit keeps the two indices of a ring of fixed-size entries that sit in system memory. One side adds entries and advances the producer index. The other side drains entries and advances the consumer index. Software sets up the ring while it is disabled. It gives a log2 entry count of up to 19, a 64-bit base address and an entry size of 16 or 32 bytes. Once the ring is running, the unit reports whether the ring is full or empty. It also presents the byte address of the slot each index points at, so a memory engine can fetch or store there directly.

Each index is one bit wider than the slot count needs. The extra bit, placed just above the programmable index field, flips on every lap. This lets a full ring be told apart from an empty one without a spare slot. The consumer register also carries a 7-bit command-error code. Software writes it independently, and advancing the consumer never disturbs it.

Top module: `cq_ptr_unit`

## Requirements
- R1: A synchronous active-high reset clears both indices, the error code, the config (log2 0, base 0, 16-byte entries) and both fault flags, so `empty`=1 and `full`=0.
- R2: With `q_en` high and the ring not full, `prod_inc` sets the producer to (producer+1) masked to log2+1 bits, so bit log2 (the lap bit) toggles when the slot field rolls over. `prod_reg` shows the producer in bits 19:0 and zero elsewhere.
- R3: With `q_en` high and the ring not empty, `cons_inc` advances only the low log2+1 bits of `cons_reg` in the same way. Bits 30:24 (error code) are left unchanged, and bits 31 and 23:20 read zero.
- R4: `full` is high exactly when the slot fields of the two indices match and their lap bits differ.
- R5: `empty` is high exactly when the two indices match over all log2+1 bits.
- R6: Each slot address is the base with bits 4:0 and 63:48 cleared, plus the index's slot field times the entry size. The entry size is 16 bytes when `cfg_ent32`=0 and 32 bytes when it is 1, and the result is 48 bits wide.
- R7: `prod_inc` while `q_en` is high and the ring is full leaves the producer unchanged and raises `ovf` for exactly the next cycle.
- R8: `cons_inc` while `q_en` is high and the ring is empty leaves the consumer unchanged and raises `unf` for exactly the next cycle.
- R9: `cfg_we` is honoured only while `q_en` is low. It then loads log2 (values above 19 become 19), base and entry size, and clears both indices. While `q_en` is high, it changes nothing.
- R10: While `q_en` is low, both increment strobes are ignored and neither fault flag rises.
- R11: `err_we` loads `err_code` into bits 30:24 of `cons_reg` on the next edge, whether or not the ring is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| q_en | input | 1 | Ring enabled |
| cfg_we | input | 1 | Config write strobe |
| cfg_log2 | input | 5 | Log2 of the slot count |
| cfg_base | input | 64 | Ring base address |
| cfg_ent32 | input | 1 | Entry size select: 0 = 16 bytes, 1 = 32 bytes |
| prod_inc | input | 1 | Advance producer |
| cons_inc | input | 1 | Advance consumer |
| err_we | input | 1 | Error code write strobe |
| err_code | input | 7 | Error code value |
| prod_reg | output | 32 | Producer register view |
| cons_reg | output | 32 | Consumer register view including the error code |
| full | output | 1 | Ring full |
| empty | output | 1 | Ring empty |
| prod_addr | output | 48 | Byte address of the producer slot |
| cons_addr | output | 48 | Byte address of the consumer slot |
| ovf | output | 1 | Producer advance refused last cycle |
| unf | output | 1 | Consumer advance refused last cycle |

## Verification
The embedded properties hold on every cycle for several rules. `full` and `empty` never assert together. Each index stays within its log2+1 bit span. The error code only moves after a write, and the config is frozen while the ring runs. A fault flag only follows a refused strobe in an enabled ring. Only the bench's scenarios can show the arithmetic itself: where the lap bit flips, the full and empty points, the exact slot addresses for both entry sizes, and the clearing of indices on a config load. It shows these by sweeping every index value for log2 sizes 0 to 3 against a model computed on its own.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

    localparam int MAX_LOG2  = 19;
    localparam int PTR_W     = MAX_LOG2 + 1;
    localparam int LOG2_W    = 5;
    localparam int ADDR_W    = 48;
    localparam int ALIGN_LSB = 5;
    localparam int ERR_W     = 7;
    localparam int ERR_LSB   = 24;
    localparam int REG_W     = 32;
    localparam int SHIFT_SM  = 4;
    localparam int SHIFT_LG  = 5;
    localparam int NUM_PTR   = 2;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LOG2_W-1:0] log2_t;

    typedef enum logic {
        SIDE_PROD = 1'b0,
        SIDE_CONS = 1'b1
    } side_e;

    typedef struct packed {
        log2_t log2;
        addr_t base;
        logic  ent32;
    } qcfg_t;

    function automatic log2_t clamp_log2(input log2_t l);
        return (l > log2_t'(MAX_LOG2)) ? log2_t'(MAX_LOG2) : l;
    endfunction

    function automatic ptr_t lap_bit(input log2_t l);
        return ptr_t'(1) << l;
    endfunction

    function automatic ptr_t span_mask(input log2_t l);
        ptr_t two_lap;
        two_lap = lap_bit(l) << 1;
        return two_lap - ptr_t'(1);
    endfunction

    function automatic ptr_t slot_mask(input log2_t l);
        return lap_bit(l) - ptr_t'(1);
    endfunction

endpackage

// File: rtl/cq_ptr.sv
module cq_ptr
    import cqp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  ptr_t span,
    output ptr_t ptr
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr + ptr_t'(1)) & span;
        end
    end

    // R2 / R3: index never leaves its log2+1 bit span
    a_r2_in_span: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((ptr & ~span) == '0));

endmodule

// File: rtl/cq_slot_addr.sv
module cq_slot_addr
    import cqp_pkg::*;
(
    input  ptr_t  ptr,
    input  qcfg_t cfg,
    output addr_t addr
);

    addr_t base_al;
    addr_t offset;
    ptr_t  slot;

    always_comb begin
        base_al = {cfg.base[ADDR_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
        slot    = ptr & slot_mask(cfg.log2);
        offset  = addr_t'(slot) << (cfg.ent32 ? SHIFT_LG : SHIFT_SM);
        addr    = base_al + offset;
    end

endmodule

// File: rtl/cq_ptr_unit.sv
module cq_ptr_unit
    import cqp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              q_en,
    input  logic              cfg_we,
    input  logic [LOG2_W-1:0] cfg_log2,
    input  logic [63:0]       cfg_base,
    input  logic              cfg_ent32,
    input  logic              prod_inc,
    input  logic              cons_inc,
    input  logic              err_we,
    input  logic [ERR_W-1:0]  err_code,
    output logic [REG_W-1:0]  prod_reg,
    output logic [REG_W-1:0]  cons_reg,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] prod_addr,
    output logic [ADDR_W-1:0] cons_addr,
    output logic              ovf,
    output logic              unf
);

    qcfg_t            cfg;
    logic [ERR_W-1:0] err_q;
    ptr_t             ptrs  [NUM_PTR];
    addr_t            addrs [NUM_PTR];
    logic             steps [NUM_PTR];
    logic             cfg_take;
    ptr_t             span;
    ptr_t             diff;

    assign cfg_take = cfg_we && !q_en;
    assign span     = span_mask(cfg.log2);
    assign diff     = (ptrs[SIDE_PROD] ^ ptrs[SIDE_CONS]) & span;
    assign full     = (diff == lap_bit(cfg.log2));
    assign empty    = (diff == '0);

    assign steps[SIDE_PROD] = q_en && prod_inc && !full;
    assign steps[SIDE_CONS] = q_en && cons_inc && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cfg_take) begin
            cfg.log2  <= clamp_log2(cfg_log2);
            cfg.base  <= cfg_base[ADDR_W-1:0];
            cfg.ent32 <= cfg_ent32;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (err_we) begin
            err_q <= err_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            ovf <= q_en && prod_inc && full;
            unf <= q_en && cons_inc && empty;
        end
    end

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_side
        cq_ptr u_ptr (
            .clk  (clk),
            .rst  (rst),
            .clr  (cfg_take),
            .step (steps[k]),
            .span (span),
            .ptr  (ptrs[k])
        );
        cq_slot_addr u_addr (
            .ptr  (ptrs[k]),
            .cfg  (cfg),
            .addr (addrs[k])
        );
    end

    assign prod_addr = addrs[SIDE_PROD];
    assign cons_addr = addrs[SIDE_CONS];

    always_comb begin
        prod_reg = '0;
        prod_reg[PTR_W-1:0] = ptrs[SIDE_PROD];
        cons_reg = '0;
        cons_reg[PTR_W-1:0] = ptrs[SIDE_CONS];
        cons_reg[ERR_LSB +: ERR_W] = err_q;
    end

    // R4 / R5: the two status flags are exclusive
    a_r4_full_not_empty: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R11 / R3: error code moves only after a write
    a_r3_err_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(err_we)) |-> $stable(cons_reg[ERR_LSB +: ERR_W]));

    // R9: config frozen while the ring runs
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(q_en)) |-> $stable(cfg));

    // R7: overflow only after a refused producer strobe
    a_r7_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        ovf |-> ($past(prod_inc) && $past(q_en) && $stable(prod_reg)));

    // R8: underflow only after a refused consumer strobe
    a_r8_unf_cause: assert property (@(posedge clk) disable iff (rst)
        unf |-> ($past(cons_inc) && $past(q_en) && $stable(cons_reg[PTR_W-1:0])));

    // R10: no fault flag after a disabled cycle
    a_r10_quiet_off: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(q_en)) |-> (!ovf && !unf));

endmodule

// File: tb/test_cq_ptr_unit.sv
module test_cq_ptr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        q_en, cfg_we, cfg_ent32, prod_inc, cons_inc, err_we;
    logic [4:0]  cfg_log2;
    logic [63:0] cfg_base;
    logic [6:0]  err_code;
    logic [31:0] prod_reg, cons_reg;
    logic        full, empty, ovf, unf;
    logic [47:0] prod_addr, cons_addr;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    int          m_l, m_p, m_c;
    bit          m_e32, m_ovf, m_unf;
    logic [63:0] m_base;
    logic [6:0]  m_err;

    always #2 clk = ~clk;

    cq_ptr_unit i_cq_ptr_unit (
        .clk(clk), .rst(rst), .q_en(q_en), .cfg_we(cfg_we), .cfg_log2(cfg_log2),
        .cfg_base(cfg_base), .cfg_ent32(cfg_ent32), .prod_inc(prod_inc),
        .cons_inc(cons_inc), .err_we(err_we), .err_code(err_code),
        .prod_reg(prod_reg), .cons_reg(cons_reg), .full(full), .empty(empty),
        .prod_addr(prod_addr), .cons_addr(cons_addr), .ovf(ovf), .unf(unf)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] slot_addr(input int ptr);
        logic [63:0] b;
        int idx;
        b   = m_base & 64'h0000_FFFF_FFFF_FFE0;
        idx = ptr & ((1 << m_l) - 1);
        return 48'(b + (64'(idx) << (m_e32 ? 5 : 4)));
    endfunction

    task automatic check_all();
        int wm, d;
        wm = (1 << (m_l + 1)) - 1;
        d  = (m_p ^ m_c) & wm;
        chk("R2", "prod_reg", 64'(prod_reg), 64'(m_p));
        chk("R3", "cons_reg", 64'(cons_reg), 64'({1'b0, m_err, 4'b0, 20'(m_c)}));
        chk("R4", "full", 64'(full), 64'(d == (1 << m_l)));
        chk("R5", "empty", 64'(empty), 64'(d == 0));
        chk("R6", "prod_addr", 64'(prod_addr), 64'(slot_addr(m_p)));
        chk("R6", "cons_addr", 64'(cons_addr), 64'(slot_addr(m_c)));
        chk("R7", "ovf", 64'(ovf), 64'(m_ovf));
        chk("R8", "unf", 64'(unf), 64'(m_unf));
    endtask

    // one clock with strobes; model per R2, R3, R7, R8, R10
    task automatic cyc(input bit pi, input bit ci);
        int wm, d;
        bit f, e;
        @(negedge clk);
        prod_inc = pi;
        cons_inc = ci;
        wm = (1 << (m_l + 1)) - 1;
        d  = (m_p ^ m_c) & wm;
        f  = (d == (1 << m_l));
        e  = (d == 0);
        m_ovf = q_en && pi && f;
        m_unf = q_en && ci && e;
        if (q_en && pi && !f) m_p = (m_p + 1) & wm;
        if (q_en && ci && !e) m_c = (m_c + 1) & wm;
        @(posedge clk);
        #1;
        prod_inc = 1'b0;
        cons_inc = 1'b0;
        check_all();
    endtask

    // R9: config load, honoured only with q_en low
    task automatic cfg_write(input int l, input logic [63:0] b, input bit e32);
        @(negedge clk);
        cfg_we = 1'b1; cfg_log2 = 5'(l); cfg_base = b; cfg_ent32 = e32;
        if (!q_en) begin
            m_l = (l > 19) ? 19 : l;
            m_base = b; m_e32 = e32; m_p = 0; m_c = 0;
        end
        m_ovf = 0; m_unf = 0;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        check_all();
    endtask

    // R11: error code write
    task automatic err_write(input logic [6:0] v);
        @(negedge clk);
        err_we = 1'b1; err_code = v;
        m_err = v; m_ovf = 0; m_unf = 0;
        @(posedge clk);
        #1;
        err_we = 1'b0;
        check_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_l = 0; m_p = 0; m_c = 0; m_e32 = 0; m_ovf = 0; m_unf = 0;
        m_base = '0; m_err = '0;
        // R1: reset state
        chk("R1", "empty after reset", 64'(empty), 64'd1);
        chk("R1", "full after reset", 64'(full), 64'd0);
        chk("R1", "cons_reg after reset", 64'(cons_reg), 64'd0);
        chk("R1", "prod_reg after reset", 64'(prod_reg), 64'd0);
    endtask

    initial begin
        rst = 1'b1; q_en = 1'b0; cfg_we = 1'b0; cfg_ent32 = 1'b0; prod_inc = 1'b0;
        cons_inc = 1'b0; err_we = 1'b0; cfg_log2 = '0; cfg_base = '0; err_code = '0;
        repeat (2) @(posedge clk);
        do_reset();
        for (int l = 0; l < 4; l++) begin
            for (int e = 0; e < 2; e++) begin
                int lap;
                lap = 1 << (l + 1);
                q_en = 1'b0;
                cfg_write(l, 64'hA5C3_1234_5678_9A5F + 64'(l * 64'h1_0040) + 64'(e * 8), e[0]);
                q_en = 1'b1;
                err_write(7'(7'h15 + l * 2 + e));
                // R2/R7: fill past full
                for (int i = 0; i <= lap / 2; i++) cyc(1'b1, 1'b0);
                // R3/R8: drain past empty
                for (int i = 0; i <= lap / 2; i++) cyc(1'b0, 1'b1);
                // mixed patterns across laps
                for (int i = 0; i < 2 * lap; i++) cyc(i % 3 != 2, i % 2 == 1);
                for (int i = 0; i < lap; i++) cyc(1'b1, 1'b1);
                // R9: config write while enabled ignored
                cfg_write(l + 1, 64'h0000_7777_0000_1000, ~e[0]);
                cyc(1'b1, 1'b0);
                // R10: strobes ignored while disabled
                q_en = 1'b0;
                cyc(1'b1, 1'b1);
                cyc(1'b0, 1'b1);
                // R11: error write while disabled, then R3 hold under advance
                err_write(7'h7F);
                q_en = 1'b1;
                cyc(1'b0, 1'b1);
            end
        end
        // R9: clamp of oversize log2 and index clear on config load
        q_en = 1'b0;
        cfg_write(27, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        q_en = 1'b1;
        for (int i = 0; i < 6; i++) cyc(1'b1, i > 2);
        // R1: reset mid-run
        err_write(7'h33);
        do_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule